// File: doc/BRIEF.md
# Sparse Hit-Channel Readout Sequencer

This block is the digital readout controller of a multi-channel front-end chip. Each channel has a trigger input. A trigger pulse sampled on a readout clock edge sets a read tag for that channel. During readout, each clock edge selects the next tagged channel and skips every untagged one. For the selected channel the block drives three things: a one-hot enable vector for the analogue output multiplexer, the channel address, and the configured chip address. An address-valid flag qualifies them.

Several chips share the output lines and are chained by a veto token. A chip takes no readout step while its veto input is high. Its veto output stays high while it still holds unread tags. Once its last tagged channel is on the outputs, the veto output follows the veto input again, which lets the next chip in the chain start. The first chip has its veto input tied low.

A late-trigger inhibit input freezes the tag set. An active-low asynchronous reset aborts readout at any moment. No reset is needed between events when every tagged channel has been read.

Top module: `sparse_readout_seq`

## Requirements
- R1: A trigger pulse on channel i, sampled on a clock edge while late_inh_i is low, tags channel i. Only tagged channels are ever presented, and each tagged channel is presented exactly once.
- R2: A trigger sampled while late_inh_i is high sets no tag. Tags that already exist are kept.
- R3: On a clock edge where veto_in_i is high, the selection does not change. chan_en_o, chan_addr_o and addr_vld_o keep their values.
- R4: On each clock edge where veto_in_i is low, the lowest-numbered unread tagged channel is presented, so readout runs in ascending address order. The first channel appears on the first such edge after the tags were latched.
- R5: While a channel is presented, addr_vld_o is 1, chan_addr_o is its index (channel 0 gives address 0) and chan_en_o has only bit chan_addr_o set. Otherwise chan_en_o is all zeros and addr_vld_o is 0.
- R6: chip_addr_o equals chip_id_i while addr_vld_o is 1 and is 0 otherwise.
- R7: veto_out_o is 1 while any tagged channel has not yet been presented. Once the last tagged channel is on the outputs, veto_out_o equals veto_in_i.
- R8: With no tags held, veto_out_o follows veto_in_i combinationally.
- R9: On the first clock edge with veto_in_i low after the last tagged channel was presented, the outputs return to the idle state of R5. The block is then ready for a new event without a reset.
- R10: Driving rst_n low clears all tags and the selection at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_CH | Per-channel trigger pulses, synchronous to clk |
| late_inh_i | input | 1 | Late-trigger inhibit; high blocks new tags |
| veto_in_i | input | 1 | Veto token from the preceding chip; high holds readout |
| chip_id_i | input | CHIP_AW | Configured chip address |
| chan_en_o | output | N_CH | One-hot analogue multiplexer enable |
| chan_addr_o | output | CH_AW | Address of the presented channel |
| chip_addr_o | output | CHIP_AW | Chip address of the presented channel |
| addr_vld_o | output | 1 | A channel is presented |
| veto_out_o | output | 1 | Veto token to the next chip |

## Verification
The main sequence is driven with four hit patterns:
- two widely spaced hits, which show that untagged channels are skipped and how the veto token is handed on;
- the extreme channels 0 and 127 together with the adjacent middle pair 63 and 64, which check the ascending order and the address and enable encoding at the edges of the range;
- hits raised while the inhibit is high, on an empty chip and on a chip that already holds a tag, which separate the blocked tags from the ones that are kept;
- a readout aborted by reset in mid-stream.

Between these runs, edges with veto held high show that the selection is frozen. Stretches with no tags show that the veto input passes straight through. Consecutive events with no reset between them show that a fully read chip restarts cleanly.

// File: rtl/sro_pkg.sv
package sro_pkg;
   typedef enum logic [0:0] {
      PRIO_SCAN    = 1'b0,
      PRIO_ISOLATE = 1'b1
   } prio_style_e;
endpackage

// File: rtl/sro_tag_bank.sv
module sro_tag_bank #(
   parameter int N_CH = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] trig_i,
   input  logic            late_inh_i,
   input  logic [N_CH-1:0] clr_i,
   output logic [N_CH-1:0] tag_q
);
   for (genvar g = 0; g < N_CH; g++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tag_q[g] <= 1'b0;
         else        tag_q[g] <= (tag_q[g] & ~clr_i[g]) | (trig_i[g] & ~late_inh_i);
      end
   end
endmodule

// File: rtl/sro_prio_enc.sv
module sro_prio_enc #(
   parameter int                  N_CH  = 128,
   parameter int                  CH_AW = 7,
   parameter sro_pkg::prio_style_e STYLE = sro_pkg::PRIO_ISOLATE
) (
   input  logic [N_CH-1:0]  req_i,
   output logic             found_o,
   output logic [CH_AW-1:0] idx_o
);
   assign found_o = |req_i;

   if (STYLE == sro_pkg::PRIO_SCAN) begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = N_CH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CH_AW'(i);
         end
      end
   end else begin : g_isolate
      logic [N_CH-1:0] lowest;
      assign lowest = req_i & (~req_i + 1'b1);
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N_CH; i++) begin
            idx_o = idx_o | (lowest[i] ? CH_AW'(i) : '0);
         end
      end
   end
endmodule

// File: rtl/sro_sel_ctrl.sv
module sro_sel_ctrl #(
   parameter int N_CH  = 128,
   parameter int CH_AW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             nxt_found_i,
   input  logic [CH_AW-1:0] nxt_idx_i,
   output logic             sel_vld_q,
   output logic [CH_AW-1:0] sel_idx_q,
   output logic [N_CH-1:0]  sel_onehot_o,
   output logic [N_CH-1:0]  clr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_vld_q <= 1'b0;
         sel_idx_q <= '0;
      end else if (step_i) begin
         sel_vld_q <= nxt_found_i;
         sel_idx_q <= nxt_found_i ? nxt_idx_i : '0;
      end
   end

   always_comb begin
      sel_onehot_o = '0;
      if (sel_vld_q) sel_onehot_o[sel_idx_q] = 1'b1;
   end

   assign clr_o = step_i ? sel_onehot_o : '0;
endmodule

// File: rtl/sparse_readout_seq.sv
module sparse_readout_seq #(
   parameter int                   N_CH    = 128,
   parameter int                   CH_AW   = $clog2(N_CH),
   parameter int                   CHIP_AW = 4,
   parameter sro_pkg::prio_style_e PRIO    = sro_pkg::PRIO_ISOLATE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CH-1:0]    trig_i,
   input  logic               late_inh_i,
   input  logic               veto_in_i,
   input  logic [CHIP_AW-1:0] chip_id_i,
   output logic [N_CH-1:0]    chan_en_o,
   output logic [CH_AW-1:0]   chan_addr_o,
   output logic [CHIP_AW-1:0] chip_addr_o,
   output logic               addr_vld_o,
   output logic               veto_out_o
);
   localparam int N_CHIPS = 1 << CHIP_AW;

   if (N_CH < 2 || (1 << CH_AW) != N_CH) begin : g_bad_ch
      $error("N_CH must be a power of two of at least 2 with CH_AW = log2(N_CH)");
   end
   if (CHIP_AW < 1 || N_CHIPS > 1024) begin : g_bad_chip
      $error("CHIP_AW out of range");
   end

   logic [N_CH-1:0]  tag_q;
   logic [N_CH-1:0]  clr;
   logic [N_CH-1:0]  sel_onehot;
   logic [N_CH-1:0]  unread;
   logic             nxt_found;
   logic [CH_AW-1:0] nxt_idx;
   logic             sel_vld_q;
   logic [CH_AW-1:0] sel_idx_q;
   logic             step;

   assign step   = ~veto_in_i;
   assign unread = tag_q & ~sel_onehot;

   sro_tag_bank #(.N_CH(N_CH)) tags_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig_i),
      .late_inh_i (late_inh_i),
      .clr_i      (clr),
      .tag_q      (tag_q)
   );

   sro_prio_enc #(.N_CH(N_CH), .CH_AW(CH_AW), .STYLE(PRIO)) enc_i (
      .req_i   (unread),
      .found_o (nxt_found),
      .idx_o   (nxt_idx)
   );

   sro_sel_ctrl #(.N_CH(N_CH), .CH_AW(CH_AW)) sel_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step),
      .nxt_found_i  (nxt_found),
      .nxt_idx_i    (nxt_idx),
      .sel_vld_q    (sel_vld_q),
      .sel_idx_q    (sel_idx_q),
      .sel_onehot_o (sel_onehot),
      .clr_o        (clr)
   );

   assign chan_en_o   = sel_onehot;
   assign chan_addr_o = sel_idx_q;
   assign addr_vld_o  = sel_vld_q;
   assign chip_addr_o = sel_vld_q ? chip_id_i : '0;
   assign veto_out_o  = (|unread) | veto_in_i;
endmodule

// File: rtl/sro_chk.sv
module sro_chk #(
   parameter int N_CH    = 128,
   parameter int CH_AW   = 7,
   parameter int CHIP_AW = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               late_inh_i,
   input logic               veto_in_i,
   input logic [CHIP_AW-1:0] chip_id_i,
   input logic [N_CH-1:0]    chan_en_o,
   input logic [CH_AW-1:0]   chan_addr_o,
   input logic [CHIP_AW-1:0] chip_addr_o,
   input logic               addr_vld_o,
   input logic               veto_out_o,
   input logic [N_CH-1:0]    tag_q
);
   // R5: enable vector is one-hot or empty, matching the valid flag
   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_en_o) && (addr_vld_o == (chan_en_o != '0)));

   // R3: a vetoed edge leaves the selection untouched
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      veto_in_i |=> ($stable(chan_addr_o) && $stable(addr_vld_o)));

   // R2: while inhibited, the tag population cannot grow
   p_no_new_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      late_inh_i |=> ($countones(tag_q) <= $countones($past(tag_q))));

   // R6: chip address qualified by the valid flag
   p_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld_o ? (chip_addr_o == chip_id_i) : (chip_addr_o == '0));

   // R8: an empty chip passes the veto through
   p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_q == '0) |-> (veto_out_o == veto_in_i));
endmodule

bind sparse_readout_seq sro_chk #(.N_CH(N_CH), .CH_AW(CH_AW), .CHIP_AW(CHIP_AW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .late_inh_i  (late_inh_i),
   .veto_in_i   (veto_in_i),
   .chip_id_i   (chip_id_i),
   .chan_en_o   (chan_en_o),
   .chan_addr_o (chan_addr_o),
   .chip_addr_o (chip_addr_o),
   .addr_vld_o  (addr_vld_o),
   .veto_out_o  (veto_out_o),
   .tag_q       (tag_q)
);

// File: tb/sparse_readout_seq_tb_top.sv
module sparse_readout_seq_tb_top;
   localparam int N_CH = 128;
   localparam int AW   = 7;
   localparam int CW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N_CH-1:0] trig = '0;
   logic            inh = 1'b0;
   logic            vin = 1'b1;
   logic [CW-1:0]   chip_id = 4'h3;
   logic [N_CH-1:0] en;
   logic [AW-1:0]   addr;
   logic [CW-1:0]   chip_addr;
   logic            vld;
   logic            vout;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sparse_readout_seq dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .late_inh_i(inh),
      .veto_in_i(vin), .chip_id_i(chip_id), .chan_en_o(en),
      .chan_addr_o(addr), .chip_addr_o(chip_addr), .addr_vld_o(vld),
      .veto_out_o(vout)
   );

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // expected output state: idle when v == 0, else channel a of this chip
   task automatic expect_sel(string req, bit v, int a, bit vo);
      logic [N_CH-1:0] exp_en;
      exp_en = '0;
      if (v) exp_en[a] = 1'b1;
      check({req, " vld"}, 128'(vld), 128'(v));
      check({req, " en"}, 128'(en), 128'(exp_en));
      if (v) check({req, " addr"}, 128'(addr), 128'(a));
      check({req, " chip"}, 128'(chip_addr), v ? 128'(chip_id) : 128'(0));
      check({req, " veto_out"}, 128'(vout), 128'(vo));
   endtask

   task automatic pulse(logic [N_CH-1:0] m);
      trig = m;
      step();
      trig = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      vin = 1'b1;
      #1;
      expect_sel("R10 reset idle", 1'b0, 0, 1'b1);
      step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic t_pass_through();
      vin = 1'b1; #1;
      check("R8 pass high", 128'(vout), 128'(1));
      vin = 1'b0; #1;
      check("R8 pass low", 128'(vout), 128'(0));
      vin = 1'b1; #1;
   endtask

   task automatic t_two_hits();
      logic [N_CH-1:0] m;
      m = '0; m[1] = 1'b1; m[124] = 1'b1;
      vin = 1'b1;
      pulse(m);
      expect_sel("R1 tagged veto busy", 1'b0, 0, 1'b1);
      step();
      expect_sel("R3 vetoed edge", 1'b0, 0, 1'b1);
      vin = 1'b0; #1;
      check("R7 busy while unread", 128'(vout), 128'(1));
      step();
      expect_sel("R4 first hit", 1'b1, 1, 1'b1);
      vin = 1'b1;
      step();
      expect_sel("R3 hold selection", 1'b1, 1, 1'b1);
      vin = 1'b0;
      step();
      expect_sel("R7 last hit hands on", 1'b1, 124, 1'b0);
      step();
      expect_sel("R9 back to idle", 1'b0, 0, 1'b0);
      vin = 1'b1;
   endtask

   task automatic t_boundary();
      logic [N_CH-1:0] m;
      chip_id = 4'hA;
      m = '0; m[0] = 1'b1; m[63] = 1'b1; m[64] = 1'b1; m[127] = 1'b1;
      vin = 1'b0;
      pulse(m);
      expect_sel("R4 none before latch", 1'b0, 0, 1'b1);
      step(); expect_sel("R5 ch0", 1'b1, 0, 1'b1);
      step(); expect_sel("R4 ch63", 1'b1, 63, 1'b1);
      step(); expect_sel("R4 ch64", 1'b1, 64, 1'b1);
      step(); expect_sel("R6 ch127", 1'b1, 127, 1'b0);
      step(); expect_sel("R9 idle after top", 1'b0, 0, 1'b0);
      vin = 1'b1;
   endtask

   task automatic t_inhibit();
      logic [N_CH-1:0] m;
      vin = 1'b1;
      inh = 1'b1;
      m = '0; m[5] = 1'b1;
      pulse(m);
      inh = 1'b0; #1;
      check("R2 no tag veto pass", 128'(vout), 128'(1));
      vin = 1'b0; #1;
      check("R2 no tag veto low", 128'(vout), 128'(0));
      step();
      expect_sel("R2 nothing to read", 1'b0, 0, 1'b0);
      vin = 1'b1;
      m = '0; m[7] = 1'b1;
      pulse(m);
      inh = 1'b1;
      m = '0; m[3] = 1'b1;
      pulse(m);
      inh = 1'b0;
      vin = 1'b0;
      step();
      expect_sel("R2 kept tag only", 1'b1, 7, 1'b0);
      step();
      expect_sel("R1 blocked tag skipped", 1'b0, 0, 1'b0);
      vin = 1'b1;
   endtask

   task automatic t_abort();
      logic [N_CH-1:0] m;
      m = '0; m[10] = 1'b1; m[20] = 1'b1; m[30] = 1'b1;
      vin = 1'b0;
      pulse(m);
      step();
      expect_sel("R4 first of three", 1'b1, 10, 1'b1);
      vin = 1'b1;
      #5;
      rst_n = 1'b0;
      #1;
      expect_sel("R10 async clear", 1'b0, 0, 1'b1);
      step();
      rst_n = 1'b1;
      vin = 1'b0;
      step();
      expect_sel("R10 tags gone", 1'b0, 0, 1'b0);
      vin = 1'b1;
   endtask

   initial begin
      t_reset();
      t_pass_through();
      t_two_hits();
      t_boundary();
      t_inhibit();
      t_abort();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule